// File: doc/BRIEF.md
# Two-Wire Bus Target with 7-bit and 10-bit Addressing

This block is a target (slave) endpoint for a two-wire open-drain serial bus. It runs from a fast system clock and oversamples the clock line and the data line. It never drives either line high. It can only pull a line low, through `scl_oe` and `sda_oe`. The block recognises START and STOP conditions. It compares the incoming address with `own_addr`, either as a single 7-bit byte or as a two-byte 10-bit sequence, and acknowledges only when the address matches.

After it is addressed, the target either receives data bytes or transmits them. Each received byte goes to the local side through a one-cycle write strobe. Each byte to be transmitted is fetched with a request/valid handshake. When the local side is not ready, the target holds the clock line low, so the controller waits.

A read with a 10-bit address follows a fixed sequence. The controller first writes the full 10-bit address. It then sends a repeated START and a header byte with the read bit set.

Top module: `i2c_tgt10`

## Requirements
- R1: A START (data falling while clock high) restarts address matching at any point. A STOP (data rising while clock high) returns the target to idle with both lines released. Clock pulses while idle are ignored and never acknowledged.
- R2: With `ten_bit`=0, the first byte after START is matched as bits [7:1] against `own_addr[6:0]`, and bit 0 is the read flag (1 = read). On a match the target holds SDA low for the whole high period of the ninth clock. On a mismatch SDA stays high and no data strobe follows.
- R3: With `ten_bit`=1, the first byte must be 11110, then `own_addr[9:8]`, then a read flag of 0. The second byte must equal `own_addr[7:0]`. Each byte that matches is acknowledged. A mismatch on either byte leaves SDA high and stops the target from responding until the next START.
- R4: A 10-bit header with the read flag set is acknowledged only if a full 10-bit write match has occurred since the last STOP. A repeated START in between is allowed. After this acknowledge the target transmits. Without that earlier match the header is not acknowledged.
- R5: In receive mode, every data byte (MSB first) yields exactly one `wr_strobe` cycle carrying the byte on `wr_data` and is acknowledged. Any number of bytes may follow one address.
- R6: When a received byte completes while `ready` is low, the target holds SCL low and issues no strobe until `ready` is high. It then strobes and acknowledges.
- R7: In transmit mode, before each byte the target raises `rd_req` and holds SCL low until `rd_valid`. It then shifts `rd_data` out MSB first. `rd_req` stays high until `rd_valid`.
- R8: If the controller leaves SDA high on the ninth clock of a transmitted byte (NACK), the target releases SDA and raises no further `rd_req` until the next START.
- R9: The target changes its own SDA drive only while SCL is low.
- R10: A repeated START in the middle of a byte discards the partial bits and returns the target to address matching.
- R11: During and right after reset, both lines are released and `wr_strobe` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the clock line |
| sda_i | input | 1 | Sensed level of the data line |
| scl_oe | output | 1 | 1 pulls the clock line low (stretch) |
| sda_oe | output | 1 | 1 pulls the data line low |
| own_addr | input | 10 | Target address; bits [6:0] are used in 7-bit mode |
| ten_bit | input | 1 | 1 selects 10-bit address matching |
| wr_strobe | output | 1 | One-cycle pulse per received data byte |
| wr_data | output | 8 | Received byte, valid with `wr_strobe` |
| ready | input | 1 | Local side can take a received byte |
| rd_req | output | 1 | Request for the next byte to transmit |
| rd_valid | input | 1 | `rd_data` is valid; completes the request |
| rd_data | input | 8 | Byte to transmit |

## Verification
The case that matters most is a received byte completing while the local side is busy. Two functions then meet in the same place: the acknowledge for that byte and the clock stretch. The bench drops `ready` before the eighth data bit and releases its own hold on SCL for the ninth clock. It then judges three things: the bus clock stays low for hundreds of cycles, no strobe appears, and once `ready` rises the clock goes high with SDA already held low for the acknowledge. A second meeting is a repeated START landing partway through a byte. The bench provokes it and then requires a clean re-match with only the later byte delivered.

// File: rtl/i2c_tgt10_pkg.sv
package i2c_tgt10_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam logic [4:0] HDR10 = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RXB,
        ST_ACK,
        ST_HOLD,
        ST_TXB,
        ST_TACK,
        ST_FETCH,
        ST_IGNORE
    } tstate_e;

    typedef enum logic [1:0] {
        K_ADDR1,
        K_ADDR2,
        K_DATA
    } kind_e;

    typedef enum logic [1:0] {
        NX_ADDR2,
        NX_DATA,
        NX_FETCH
    } next_e;

endpackage

// File: rtl/i2c_tgt10_lines.sv
module i2c_tgt10_lines #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [1:0] raw;
    logic [1:0] now;
    logic [1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= {pipe_q[STAGES-1:0], raw[g]};
        end
        assign now[g]  = pipe_q[STAGES-1];
        assign prev[g] = pipe_q[STAGES];
    end

    assign scl_s     = now[1];
    assign sda_s     = now[0];
    assign scl_rise  = now[1] & ~prev[1];
    assign scl_fall  = ~now[1] & prev[1];
    assign bus_start = now[1] & prev[1] & prev[0] & ~now[0];
    assign bus_stop  = now[1] & prev[1] & ~prev[0] & now[0];
endmodule

// File: rtl/i2c_tgt10_match.sv
module i2c_tgt10_match
    import i2c_tgt10_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit,
    input  logic              matched10,
    output logic              hit_first_w,
    output logic              hit_first_r,
    output logic              hit_second
);
    logic hdr_ok;
    logic short_ok;

    always_comb begin
        hdr_ok      = (rx_byte[7:3] == HDR10) && (rx_byte[2:1] == own_addr[9:8]);
        short_ok    = (rx_byte[7:1] == own_addr[6:0]);
        hit_first_w = ten_bit ? (hdr_ok && !rx_byte[0]) : (short_ok && !rx_byte[0]);
        hit_first_r = ten_bit ? (hdr_ok && rx_byte[0] && matched10)
                              : (short_ok && rx_byte[0]);
        hit_second  = (rx_byte == own_addr[7:0]);
    end
endmodule

// File: rtl/i2c_tgt10.sv
module i2c_tgt10
    import i2c_tgt10_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit,
    output logic              wr_strobe,
    output logic [BYTE_W-1:0] wr_data,
    input  logic              ready,
    output logic              rd_req,
    input  logic              rd_valid,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    typedef struct packed {
        tstate_e           st;
        kind_e             kind;
        next_e             nxt;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              nack;
        logic              matched10;
        logic              scl_oe;
        logic              sda_oe;
        logic              wr_stb;
        logic [BYTE_W-1:0] wr_dat;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_IDLE, kind: K_ADDR1, nxt: NX_DATA, cnt: '0, sh: '0,
        nack: 1'b0, matched10: 1'b0, scl_oe: 1'b0, sda_oe: 1'b0,
        wr_stb: 1'b0, wr_dat: '0
    };

    regs_t r_q, r_d;

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic hit_first_w, hit_first_r, hit_second;

    i2c_tgt10_lines #(.STAGES(SYNC_STAGES)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_tgt10_match u_match (
        .rx_byte     (r_q.sh),
        .own_addr    (own_addr),
        .ten_bit     (ten_bit),
        .matched10   (r_q.matched10),
        .hit_first_w (hit_first_w),
        .hit_first_r (hit_first_r),
        .hit_second  (hit_second)
    );

    always_comb begin
        r_d        = r_q;
        r_d.wr_stb = 1'b0;

        unique case (r_q.st)
            ST_IDLE, ST_IGNORE: begin
            end

            ST_RXB: begin
                if (scl_rise) begin
                    r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_s};
                    r_d.cnt = r_q.cnt + 1'b1;
                end else if (scl_fall && r_q.cnt == LAST_BIT) begin
                    r_d.cnt = '0;
                    unique case (r_q.kind)
                        K_ADDR1: begin
                            if (hit_first_w) begin
                                r_d.sda_oe = 1'b1;
                                r_d.st     = ST_ACK;
                                r_d.nxt    = ten_bit ? NX_ADDR2 : NX_DATA;
                            end else if (hit_first_r) begin
                                r_d.sda_oe = 1'b1;
                                r_d.st     = ST_ACK;
                                r_d.nxt    = NX_FETCH;
                            end else begin
                                r_d.st        = ST_IGNORE;
                                r_d.matched10 = 1'b0;
                            end
                        end
                        K_ADDR2: begin
                            if (hit_second) begin
                                r_d.sda_oe    = 1'b1;
                                r_d.st        = ST_ACK;
                                r_d.nxt       = NX_DATA;
                                r_d.matched10 = 1'b1;
                            end else begin
                                r_d.st        = ST_IGNORE;
                                r_d.matched10 = 1'b0;
                            end
                        end
                        default: begin
                            if (ready) begin
                                r_d.wr_stb = 1'b1;
                                r_d.wr_dat = r_q.sh;
                                r_d.sda_oe = 1'b1;
                                r_d.st     = ST_ACK;
                                r_d.nxt    = NX_DATA;
                            end else begin
                                r_d.scl_oe = 1'b1;
                                r_d.st     = ST_HOLD;
                                r_d.nxt    = NX_DATA;
                            end
                        end
                    endcase
                end
            end

            ST_HOLD: begin
                // sda is set one cycle before scl is let go
                if (!r_q.sda_oe) begin
                    if (ready) begin
                        r_d.wr_stb = 1'b1;
                        r_d.wr_dat = r_q.sh;
                        r_d.sda_oe = 1'b1;
                    end
                end else begin
                    r_d.scl_oe = 1'b0;
                    r_d.st     = ST_ACK;
                end
            end

            ST_ACK: begin
                if (scl_fall) begin
                    r_d.sda_oe = 1'b0;
                    r_d.cnt    = '0;
                    unique case (r_q.nxt)
                        NX_ADDR2: begin
                            r_d.st   = ST_RXB;
                            r_d.kind = K_ADDR2;
                        end
                        NX_FETCH: begin
                            r_d.st     = ST_FETCH;
                            r_d.scl_oe = 1'b1;
                        end
                        default: begin
                            r_d.st   = ST_RXB;
                            r_d.kind = K_DATA;
                        end
                    endcase
                end
            end

            ST_FETCH: begin
                if (rd_valid) begin
                    r_d.sh     = rd_data;
                    r_d.sda_oe = ~rd_data[BYTE_W-1];
                    r_d.cnt    = '0;
                    r_d.st     = ST_TXB;
                end
            end

            ST_TXB: begin
                r_d.scl_oe = 1'b0;
                if (scl_rise) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end else if (scl_fall) begin
                    if (r_q.cnt == LAST_BIT) begin
                        r_d.sda_oe = 1'b0;
                        r_d.st     = ST_TACK;
                    end else begin
                        r_d.sh     = {r_q.sh[BYTE_W-2:0], 1'b0};
                        r_d.sda_oe = ~r_q.sh[BYTE_W-2];
                    end
                end
            end

            ST_TACK: begin
                if (scl_rise) begin
                    r_d.nack = sda_s;
                end else if (scl_fall) begin
                    if (r_q.nack) begin
                        r_d.st = ST_IGNORE;
                    end else begin
                        r_d.st     = ST_FETCH;
                        r_d.scl_oe = 1'b1;
                    end
                end
            end

            default: r_d.st = ST_IDLE;
        endcase

        if (bus_stop) begin
            r_d.st        = ST_IDLE;
            r_d.matched10 = 1'b0;
            r_d.sda_oe    = 1'b0;
            r_d.scl_oe    = 1'b0;
        end
        if (bus_start) begin
            r_d.st     = ST_RXB;
            r_d.kind   = K_ADDR1;
            r_d.cnt    = '0;
            r_d.sda_oe = 1'b0;
            r_d.scl_oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign scl_oe    = r_q.scl_oe;
    assign sda_oe    = r_q.sda_oe;
    assign wr_strobe = r_q.wr_stb;
    assign wr_data   = r_q.wr_dat;
    assign rd_req    = (r_q.st == ST_FETCH);

endmodule

// File: rtl/i2c_tgt10_chk.sv
module i2c_tgt10_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic bus_start,
    input logic bus_stop,
    input logic scl_oe,
    input logic sda_oe,
    input logic wr_strobe,
    input logic ready,
    input logic rd_req,
    input logic rd_valid
);
    // R9
    sda_move_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R7
    fetch_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> scl_oe);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> rd_req);

    // R6
    strobe_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> $past(ready));

    // R1
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (!sda_oe && !scl_oe));

    // R1
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> (!sda_oe && !scl_oe && !rd_req));

    // R5
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_strobe, rd_req}));
endmodule

bind i2c_tgt10 i2c_tgt10_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .wr_strobe (wr_strobe),
    .ready     (ready),
    .rd_req    (rd_req),
    .rd_valid  (rd_valid)
);

// File: tb/i2c_tgt10_test.sv
`timescale 1ns/1ps
module i2c_tgt10_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_ctl_low = 1'b0;
    logic sda_ctl_low = 1'b0;
    logic scl_bus, sda_bus;
    logic scl_oe, sda_oe;
    logic [9:0] own_addr = 10'h2A5;
    logic ten_bit = 1'b0;
    logic wr_strobe;
    logic [7:0] wr_data;
    logic ready = 1'b1;
    logic rd_req;
    logic rd_valid = 1'b0;
    logic [7:0] rd_data = 8'h00;

    int n_checks = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    logic [7:0] wr_last = 8'h00;
    int rd_idx = 0;
    int rd_lat = 60;
    bit mon_en = 1'b0;
    int viol = 0;
    logic prev_oe = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign scl_bus = ~(scl_ctl_low | scl_oe);
    assign sda_bus = ~(sda_ctl_low | sda_oe);

    i2c_tgt10 uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .ten_bit(ten_bit),
        .wr_strobe(wr_strobe), .wr_data(wr_data), .ready(ready),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [7:0] tx_val(input int i);
        return 8'hA7 + 8'(i * 59);
    endfunction

    // {ten, addr[9:0], data[7:0], ack_first, ack_second}
    localparam logic [20:0] VEC [0:7] = '{
        {1'b0, 10'h025, 8'h5A, 1'b1, 1'b1},
        {1'b0, 10'h026, 8'h11, 1'b0, 1'b0},
        {1'b1, 10'h2A5, 8'hC3, 1'b1, 1'b1},
        {1'b1, 10'h1A5, 8'h44, 1'b0, 1'b0},
        {1'b1, 10'h2A4, 8'h55, 1'b1, 1'b0},
        {1'b0, 10'h024, 8'h66, 1'b0, 1'b0},
        {1'b1, 10'h2A5, 8'h00, 1'b1, 1'b1},
        {1'b0, 10'h025, 8'hFF, 1'b1, 1'b1}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_ctl_low = 1'b0; wait_cyc(20);
        scl_ctl_low = 1'b0; wait_scl_high(); wait_cyc(30);
        sda_ctl_low = 1'b1; wait_cyc(30);
        scl_ctl_low = 1'b1; wait_cyc(20);
    endtask

    task automatic bus_stop();
        sda_ctl_low = 1'b1; wait_cyc(20);
        scl_ctl_low = 1'b0; wait_scl_high(); wait_cyc(30);
        sda_ctl_low = 1'b0; wait_cyc(40);
    endtask

    task automatic put_bit(input logic b);
        sda_ctl_low = ~b; wait_cyc(30);
        scl_ctl_low = 1'b0; wait_scl_high(); wait_cyc(40);
        scl_ctl_low = 1'b1; wait_cyc(10);
    endtask

    task automatic get_bit(output logic b);
        sda_ctl_low = 1'b0; wait_cyc(30);
        scl_ctl_low = 1'b0; wait_scl_high(); wait_cyc(20);
        b = sda_bus; wait_cyc(20);
        scl_ctl_low = 1'b1; wait_cyc(10);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~ack);
    endtask

    // local write side
    initial forever begin
        @(negedge clk);
        if (wr_strobe) begin
            wr_last = wr_data;
            wr_cnt++;
        end
    end

    // local read side
    initial forever begin
        @(negedge clk);
        if (rd_req) begin
            repeat (rd_lat) @(negedge clk);
            rd_data  = tx_val(rd_idx);
            rd_valid = 1'b1;
            @(negedge clk);
            rd_valid = 1'b0;
            rd_idx++;
        end
    end

    // R9 monitor: target drive must not move while the clock line is high
    initial forever begin
        @(negedge clk);
        if (mon_en && scl_bus && (sda_oe != prev_oe)) viol++;
        prev_oe = sda_oe;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run hung actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack, ack2;
        logic [7:0] v0, v1;
        int c0, base;

        // R11 reset state
        wait_cyc(5);
        check(scl_oe == 1'b0 && sda_oe == 1'b0, "R11", "lines released in reset",
              {scl_oe, sda_oe}, 0);
        check(wr_strobe == 1'b0 && rd_req == 1'b0, "R11", "local strobes in reset",
              {wr_strobe, rd_req}, 0);
        rst_n = 1'b1;
        wait_cyc(20);
        check(scl_oe == 1'b0 && sda_oe == 1'b0 && rd_req == 1'b0, "R11",
              "released after reset", {scl_oe, sda_oe, rd_req}, 0);

        // vector table: single-byte writes in both address modes
        for (int i = 0; i < 8; i++) begin
            logic [20:0] vv;
            vv = VEC[i];
            ten_bit = vv[20];
            c0 = wr_cnt;
            ack2 = 1'b0;
            bus_start();
            if (!vv[20]) begin
                send_byte({vv[16:10], 1'b0}, ack);
                check(ack == vv[1], "R2", "7-bit address ack", ack, vv[1]);
                ack2 = ack;
            end else begin
                send_byte({5'b11110, vv[19:18], 1'b0}, ack);
                check(ack == vv[1], "R3", "10-bit header ack", ack, vv[1]);
                if (ack) begin
                    send_byte(vv[17:10], ack2);
                    check(ack2 == vv[0], "R3", "10-bit low byte ack", ack2, vv[0]);
                end
            end
            if (ack2) begin
                send_byte(vv[9:2], ack);
                check(ack == 1'b1, "R5", "data byte ack", ack, 1);
                check(wr_cnt == c0 + 1 && wr_last == vv[9:2], "R5", "strobed byte",
                      wr_last, vv[9:2]);
            end else begin
                check(wr_cnt == c0, "R2", "no strobe when unaddressed", wr_cnt, c0);
            end
            bus_stop();
        end

        // R5 several bytes under one address
        ten_bit = 1'b0;
        c0 = wr_cnt;
        bus_start();
        send_byte(8'h4A, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        check(ack == 1'b1 && wr_cnt == c0 + 3 && wr_last == 8'h33, "R5",
              "three-byte write", wr_last, 8'h33);
        bus_stop();

        // R6 stretch while local side is busy at the end of a byte
        ready = 1'b0;
        c0 = wr_cnt;
        bus_start();
        send_byte(8'h4A, ack);
        check(ack == 1'b1, "R6", "address ack before stall", ack, 1);
        for (int i = 7; i >= 0; i--) put_bit(v0[0] | (8'h9C >> i) & 1'b1);
        sda_ctl_low = 1'b0; wait_cyc(30);
        scl_ctl_low = 1'b0; wait_cyc(300);
        check(scl_bus == 1'b0, "R6", "clock held low while busy", scl_bus, 0);
        check(wr_cnt == c0, "R6", "no strobe while busy", wr_cnt, c0);
        ready = 1'b1;
        wait_scl_high(); wait_cyc(20);
        check(sda_bus == 1'b0, "R6", "ack after ready", sda_bus, 0);
        check(wr_cnt == c0 + 1 && wr_last == 8'h9C, "R6", "byte after ready",
              wr_last, 8'h9C);
        wait_cyc(20);
        scl_ctl_low = 1'b1; wait_cyc(10);
        bus_stop();

        // R7 R8 R9 7-bit read of two bytes, NACK on the last
        base = rd_idx;
        mon_en = 1'b1;
        bus_start();
        send_byte(8'h4B, ack);
        check(ack == 1'b1, "R7", "read address ack", ack, 1);
        recv_byte(v0, 1'b1);
        check(v0 == tx_val(base), "R7", "first read byte", v0, tx_val(base));
        recv_byte(v1, 1'b0);
        check(v1 == tx_val(base + 1), "R7", "second read byte", v1, tx_val(base + 1));
        wait_cyc(150);
        check(sda_bus == 1'b1 && sda_oe == 1'b0, "R8", "data released after NACK",
              sda_oe, 0);
        check(rd_idx == base + 2 && rd_req == 1'b0, "R8", "no fetch after NACK",
              rd_idx, base + 2);
        bus_stop();
        mon_en = 1'b0;
        check(viol == 0, "R9", "drive moved while clock high", viol, 0);

        // R4 10-bit read through repeated START
        ten_bit = 1'b1;
        base = rd_idx;
        bus_start();
        send_byte(8'hF4, ack);
        send_byte(8'hA5, ack2);
        check(ack && ack2, "R3", "10-bit write match", {ack, ack2}, 3);
        bus_start();
        send_byte(8'hF5, ack);
        check(ack == 1'b1, "R4", "read header after match", ack, 1);
        recv_byte(v0, 1'b0);
        check(v0 == tx_val(base), "R4", "10-bit read byte", v0, tx_val(base));
        bus_stop();

        // R4 read header with no prior match since STOP
        bus_start();
        send_byte(8'hF5, ack);
        check(ack == 1'b0, "R4", "read header without match", ack, 0);
        bus_stop();

        // R10 repeated START partway through a data byte
        ten_bit = 1'b0;
        c0 = wr_cnt;
        bus_start();
        send_byte(8'h4A, ack);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        send_byte(8'h4A, ack);
        check(ack == 1'b1, "R10", "re-match after repeated START", ack, 1);
        send_byte(8'h77, ack);
        check(wr_cnt == c0 + 1 && wr_last == 8'h77, "R10", "partial byte dropped",
              wr_last, 8'h77);
        bus_stop();

        // R1 clocks after STOP are ignored
        c0 = wr_cnt;
        bus_start();
        send_byte(8'h4A, ack);
        bus_stop();
        send_byte(8'h4A, ack);
        check(ack == 1'b0, "R1", "no ack while idle", ack, 0);
        check(wr_cnt == c0, "R1", "no strobe while idle", wr_cnt, c0);
        bus_stop();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule